// File: doc/BRIEF.md
# Decimal Event Record Parser

This block sits after a serial byte receiver. It turns a stream of ASCII characters into event records. Each record holds a decimal timestamp and an x and y coordinate. A letter follows each number and names the field that number belongs to. A final marker letter closes the record. Digits build up in a wide accumulator. Each field letter moves the accumulated number into a private staging slot.

When the closing marker arrives, the three staged values move to the outputs in a single cycle. The block raises a one-cycle pulse at the same time. Downstream sampling logic therefore never sees a record that is only partly updated. The block also keeps the timestamp of the record committed before the current one, so a consumer can detect that the timestamp has changed.

Character codes: digits are `0x30`–`0x39`, `t` (`0x74`) ends a timestamp, `x` (`0x78`) ends an x field, `y` (`0x79`) ends a y field, and `e` (`0x65`) closes a record.

Top module: `event_string_parser`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `ts_out`, `x_out`, `y_out` and `prev_ts` at zero and `event_valid` low.
- R2: A byte is consumed only at the first clock edge at which `rx_strobe` is high after having been low. Bytes present while the strobe stays high are not consumed.
- R3: A digit byte sets the accumulator to ten times its value plus the digit, modulo 2^ACC_W. With ACC_W = 64, the string 18446744073709551615 yields all ones and 18446744073709551616 yields zero.
- R4: `t`, `x` and `y` copy the accumulator into the staging slot of their field. The output registers do not change until `e` is consumed.
- R5: Consuming `e` loads all three outputs from staging in the same cycle and raises `event_valid` for exactly one cycle. The outputs are visible from the edge that consumes the byte.
- R6: After `e`, the staging slots are zero. A lone `e` then commits timestamp 0, x 0 and y 0.
- R7: Any non-digit byte clears the accumulator. A byte that is neither a digit nor one of `t`, `x`, `y`, `e` has no other effect. For example, `12?5t3x4ye` commits timestamp 5.
- R8: On each commit, `prev_ts` takes the value `ts_out` had just before that commit.
- R9: The x and y fields keep the low COORD_W bits of the accumulator. With COORD_W = 16, the value 65537 gives 1 and 70000 gives 4464.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Byte from the serial receiver |
| rx_strobe | input | 1 | Data-received level; its rising edge marks a new byte |
| ts_out | output | ACC_W | Committed timestamp |
| x_out | output | COORD_W | Committed x coordinate |
| y_out | output | COORD_W | Committed y coordinate |
| event_valid | output | 1 | One-cycle pulse when a record is committed |
| prev_ts | output | ACC_W | Timestamp of the record committed before the current one |

## Verification
The bench builds the block with its default widths: a 64-bit accumulator and 16-bit coordinates. At these widths, twenty-digit strings reach the exact top of the accumulator range and one step past it, so the wrap to zero can be checked. Five-digit coordinates likewise cross the 16-bit limit, so the truncation of the x and y fields can be observed directly. Directed strings cover garbage bytes in the middle of a number, a lone closing marker, and a strobe held high while the byte changes.

// File: rtl/evp_pkg.sv
package evp_pkg;

    localparam int EVP_ACC_W   = 64;
    localparam int EVP_COORD_W = 16;

    typedef enum logic [2:0] {
        CK_DIGIT,
        CK_TS,
        CK_XF,
        CK_YF,
        CK_END,
        CK_OTHER
    } char_kind_e;

    typedef struct packed {
        char_kind_e  kind;
        logic [3:0]  digit;
    } char_info_t;

    function automatic char_info_t classify(input logic [7:0] b);
        char_info_t r;
        r.digit = 4'd0;
        if (b >= 8'h30 && b <= 8'h39) begin
            r.kind  = CK_DIGIT;
            r.digit = 4'(b - 8'h30);
        end else begin
            case (b)
                8'h74:   r.kind = CK_TS;
                8'h78:   r.kind = CK_XF;
                8'h79:   r.kind = CK_YF;
                8'h65:   r.kind = CK_END;
                default: r.kind = CK_OTHER;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/evp_strobe_edge.sv
module evp_strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic fresh
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b0;
        else     strobe_q <= strobe;
    end

    assign fresh = strobe & ~strobe_q;
endmodule

// File: rtl/evp_digit_acc.sv
module evp_digit_acc
    import evp_pkg::*;
#(
    parameter int ACC_W = EVP_ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  char_info_t       info,
    output logic [ACC_W-1:0] acc
);
    logic [ACC_W-1:0] acc_next;

    always_comb begin
        acc_next = acc;
        if (take) begin
            if (info.kind == CK_DIGIT)
                acc_next = acc * ACC_W'(10) + ACC_W'(info.digit);
            else
                acc_next = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= acc_next;
    end
endmodule

// File: rtl/evp_field_stage.sv
module evp_field_stage
    import evp_pkg::*;
#(
    parameter int ACC_W   = EVP_ACC_W,
    parameter int COORD_W = EVP_COORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  char_kind_e         kind,
    input  logic [ACC_W-1:0]   acc,
    output logic [ACC_W-1:0]   ts_q,
    output logic [COORD_W-1:0] x_q,
    output logic [COORD_W-1:0] y_q,
    output logic               commit_q,
    output logic [ACC_W-1:0]   prev_q
);
    logic [ACC_W-1:0]   ts_stg;
    logic [COORD_W-1:0] x_stg;
    logic [COORD_W-1:0] y_stg;
    logic [COORD_W-1:0] acc_lo;

    assign acc_lo = acc[COORD_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_stg   <= '0;
            x_stg    <= '0;
            y_stg    <= '0;
            ts_q     <= '0;
            x_q      <= '0;
            y_q      <= '0;
            prev_q   <= '0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (take) begin
                case (kind)
                    CK_TS: ts_stg <= acc;
                    CK_XF: x_stg  <= acc_lo;
                    CK_YF: y_stg  <= acc_lo;
                    CK_END: begin
                        prev_q   <= ts_q;
                        ts_q     <= ts_stg;
                        x_q      <= x_stg;
                        y_q      <= y_stg;
                        commit_q <= 1'b1;
                        ts_stg   <= '0;
                        x_stg    <= '0;
                        y_stg    <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/event_string_parser.sv
module event_string_parser
    import evp_pkg::*;
#(
    parameter int ACC_W   = EVP_ACC_W,
    parameter int COORD_W = EVP_COORD_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         rx_byte,
    input  logic               rx_strobe,
    output logic [ACC_W-1:0]   ts_out,
    output logic [COORD_W-1:0] x_out,
    output logic [COORD_W-1:0] y_out,
    output logic               event_valid,
    output logic [ACC_W-1:0]   prev_ts
);
    logic             take;
    char_info_t       info;
    logic [ACC_W-1:0] acc;

    assign info = classify(rx_byte);

    evp_strobe_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .strobe (rx_strobe),
        .fresh  (take)
    );

    evp_digit_acc #(.ACC_W(ACC_W)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .info (info),
        .acc  (acc)
    );

    evp_field_stage #(.ACC_W(ACC_W), .COORD_W(COORD_W)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .kind     (info.kind),
        .acc      (acc),
        .ts_q     (ts_out),
        .x_q      (x_out),
        .y_q      (y_out),
        .commit_q (event_valid),
        .prev_q   (prev_ts)
    );
endmodule

// File: rtl/evp_checker.sv
module evp_checker #(
    parameter int ACC_W   = 64,
    parameter int COORD_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [7:0]         rx_byte,
    input logic               rx_strobe,
    input logic [ACC_W-1:0]   ts_out,
    input logic [COORD_W-1:0] x_out,
    input logic [COORD_W-1:0] y_out,
    input logic               event_valid,
    input logic [ACC_W-1:0]   prev_ts
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (ts_out == '0 && x_out == '0 && y_out == '0 && !event_valid));

    assert_no_edge_no_commit_R2: assert property (@(posedge clk) disable iff (rst)
        !$rose(rx_strobe) |=> !event_valid);

    assert_outputs_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !event_valid |-> ($stable(ts_out) && $stable(x_out) && $stable(y_out)));

    assert_end_commits_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(rx_strobe) && rx_byte == 8'h65) |=> event_valid);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        event_valid |=> !event_valid);

    assert_prev_ts_R8: assert property (@(posedge clk) disable iff (rst)
        event_valid |-> prev_ts == $past(ts_out));
endmodule

bind event_string_parser evp_checker #(.ACC_W(ACC_W), .COORD_W(COORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_byte     (rx_byte),
    .rx_strobe   (rx_strobe),
    .ts_out      (ts_out),
    .x_out       (x_out),
    .y_out       (y_out),
    .event_valid (event_valid),
    .prev_ts     (prev_ts)
);

// File: tb/event_string_parser_test.sv
`timescale 1ns/1ps
module event_string_parser_test;
    localparam int ACC_W   = 64;
    localparam int COORD_W = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [7:0]         rx_byte = 8'h00;
    logic               rx_strobe = 1'b0;
    logic [ACC_W-1:0]   ts_out;
    logic [COORD_W-1:0] x_out;
    logic [COORD_W-1:0] y_out;
    logic               event_valid;
    logic [ACC_W-1:0]   prev_ts;

    int checks = 0;
    int fails  = 0;
    logic pulse_seen;
    logic pulse_after;

    always #4 clk = ~clk;

    event_string_parser #(.ACC_W(ACC_W), .COORD_W(COORD_W)) uut (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_strobe(rx_strobe),
        .ts_out(ts_out), .x_out(x_out), .y_out(y_out),
        .event_valid(event_valid), .prev_ts(prev_ts)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_byte   = b;
        rx_strobe = 1'b1;
        @(negedge clk);
        pulse_seen = event_valid;
        rx_strobe  = 1'b0;
        @(negedge clk);
        pulse_after = event_valid;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
    endtask

    task automatic t_reset();
        chk("R1 ts", ts_out, 0);
        chk("R1 x", 64'(x_out), 0);
        chk("R1 y", 64'(y_out), 0);
        chk("R1 prev", prev_ts, 0);
        chk("R1 valid", 64'(event_valid), 0);
    endtask

    task automatic t_basic();
        send_str("2104t8x13y");
        chk("R4 ts held", ts_out, 0);
        chk("R4 x held", 64'(x_out), 0);
        send_byte("e");
        chk("R5 pulse", 64'(pulse_seen), 1);
        chk("R5 pulse one cycle", 64'(pulse_after), 0);
        chk("R5 ts", ts_out, 2104);
        chk("R5 x", 64'(x_out), 8);
        chk("R5 y", 64'(y_out), 13);
    endtask

    task automatic t_prev();
        send_str("77t1x2ye");
        chk("R8 prev", prev_ts, 2104);
        chk("R8 ts", ts_out, 77);
    endtask

    task automatic t_garbage();
        send_str("12?5t3x4ye");
        chk("R7 ts after garbage", ts_out, 5);
        chk("R7 x", 64'(x_out), 3);
        chk("R7 y", 64'(y_out), 4);
    endtask

    task automatic t_stage_clear();
        send_byte("e");
        chk("R6 pulse", 64'(pulse_seen), 1);
        chk("R6 ts", ts_out, 0);
        chk("R6 x", 64'(x_out), 0);
        chk("R6 y", 64'(y_out), 0);
        chk("R6 prev", prev_ts, 5);
    endtask

    task automatic t_held_strobe();
        @(negedge clk);
        rx_byte = "1"; rx_strobe = 1'b1;
        @(negedge clk);
        rx_byte = "9";
        repeat (3) @(negedge clk);
        rx_byte = "e";
        repeat (2) @(negedge clk);
        chk("R2 no commit while held", 64'(event_valid), 0);
        rx_strobe = 1'b0;
        @(negedge clk);
        send_str("t1x1ye");
        chk("R2 ts", ts_out, 1);
    endtask

    task automatic t_wide();
        send_str("18446744073709551615t0x0ye");
        chk("R3 max", ts_out, 64'hFFFF_FFFF_FFFF_FFFF);
        send_str("18446744073709551616t0x0ye");
        chk("R3 wrap", ts_out, 0);
    endtask

    task automatic t_trunc();
        send_str("9t65537x70000ye");
        chk("R9 x", 64'(x_out), 1);
        chk("R9 y", 64'(y_out), 4464);
        chk("R9 ts", ts_out, 9);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_prev();
        t_garbage();
        t_stage_clear();
        t_held_strobe();
        t_wide();
        t_trunc();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule